// File: doc/BRIEF.md
# PTP Hardware Time Counter with Step and Rate Trim

This block keeps a precision-time-protocol clock in hardware. The time value has a 48-bit seconds part and a 30-bit nanoseconds part. The nanoseconds part always stays below one billion. On every reference tick that the `tick_i` enable marks, the counter advances by a nominal 8 ns. A signed fractional frequency trim can stretch that tick to 9 ns or shrink it to 7 ns. The live time goes straight to a timestamp capture unit on `time_sec_o` and `time_ns_o`.

A host controls the block through a flat map of 16-bit words. It stages a set time, a step amount and a rate word. It then writes a command word whose bits act once, in the cycle of the write. These bits start or stop the counter, clear it, load the staged time, take a coherent snapshot for reading, or step the seconds or nanoseconds. Reads come back on `rd_data_o` one clock after `rd_addr_i` is presented.

Word addresses: 0 command, 1/2/3 set seconds high/middle/low, 4/5 set nanoseconds high (bits 13:0)/low, 6/7 rate high/low, 8/9 step high/low, 10/11/12 snapshot seconds high/middle/low, 13/14 snapshot nanoseconds high/low.

Top module: `ptp_hw_clock`

## Requirements
- R1: After the synchronous reset `rst`: time is zero, the counter is stopped, the rate words and the accumulator are zero, and `rd_data_o` is 0.
- R2: Ticks advance time only while the counter is running. Command bit 2 starts the counter. Command bit 1 stops it, and bit 1 wins when both bits are written together. A stopped counter holds its value.
- R3: With a zero rate, every running tick adds 8 ns. A nanoseconds value that reaches 1,000,000,000 wraps and adds one to the seconds. The nanoseconds output never reaches 1,000,000,000.
- R4: The rate word is made of bit 15 of word 6 (1 means faster), bits 13:0 of word 6 as the upper magnitude bits, and word 7 as the lower 16 bits. On each running tick, the 30-bit magnitude is added to (faster) or subtracted from (slower) a 31-bit fraction counted in units of 2^-31 ns. A carry makes that tick 9 ns, and a borrow makes it 7 ns.
- R5: Command bit 4 copies the staged set words into the time in the cycle of the write, with no tick added. A staged nanoseconds value of 1,000,000,000 or more wraps and adds one second.
- R6: Command bit 3 latches the time as it stood before that edge into the snapshot words. Those words keep their value until the next snapshot, whatever the live time does.
- R7: Command bit 5 steps the seconds by word 9. Bit 15 of word 8 picks add (1) or subtract (0). The result wraps modulo 2^48. A tick in the same cycle still applies.
- R8: Command bit 6 adds the 30-bit amount {word 8 bits 13:0, word 9} to the nanoseconds, together with any tick in the same cycle. The sum wraps and carries one or two seconds.
- R9: Command bit 0 clears the time, the rate words and the fraction accumulator, and stops the counter.
- R10: `rd_data_o` is registered: it shows the word at the address presented one clock earlier. Words 6 and 7 read back the rate, with bit 14 of word 6 always 0. Words 10 to 14 read the snapshot. Every other address reads 0.
- R11: When several command bits are written together, clear wins over load, and load wins over both steps. Each command acts exactly once and does not repeat in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable for each reference tick |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 4 | Host write word address |
| wr_data_i | input | 16 | Host write data |
| rd_addr_i | input | 4 | Host read word address |
| rd_data_o | output | 16 | Registered read data |
| time_sec_o | output | 48 | Live seconds |
| time_ns_o | output | 30 | Live nanoseconds |

## Verification
The bench builds the block with its default parameters: a 31-bit fraction and an 8 ns nominal tick. With these values a rate magnitude of 2^29 gives exactly one carry or borrow every fourth tick, so the count of 7 ns and 9 ns ticks can be predicted by hand. The full 30-bit nanoseconds step lets a single write combined with a tick cross two seconds. A 48-bit seconds field is wide enough to show the wrap below zero.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int WORD_W = 16;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 30;
  localparam int HI_W   = NS_W - WORD_W;
  localparam int ADDR_W = 4;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_SET_SH = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET_SM = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET_SL = 4'd3;
  localparam logic [ADDR_W-1:0] A_SET_NH = 4'd4;
  localparam logic [ADDR_W-1:0] A_SET_NL = 4'd5;
  localparam logic [ADDR_W-1:0] A_RATE_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_RATE_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_STEP_H = 4'd8;
  localparam logic [ADDR_W-1:0] A_STEP_L = 4'd9;
  localparam logic [ADDR_W-1:0] A_RD_SH  = 4'd10;
  localparam logic [ADDR_W-1:0] A_RD_SM  = 4'd11;
  localparam logic [ADDR_W-1:0] A_RD_SL  = 4'd12;
  localparam logic [ADDR_W-1:0] A_RD_NH  = 4'd13;
  localparam logic [ADDR_W-1:0] A_RD_NL  = 4'd14;

  typedef struct packed {
    logic step_n;
    logic step_s;
    logic load;
    logic snap;
    logic on;
    logic off;
    logic clr;
  } cmd_t;
endpackage

// File: rtl/phc_regs.sv
module phc_regs
  import phc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEC_W-1:0]  snap_sec,
  input  logic [NS_W-1:0]   snap_ns,
  output cmd_t              cmd,
  output logic              running,
  output logic [SEC_W-1:0]  set_sec,
  output logic [NS_W-1:0]   set_ns,
  output logic              rate_fast,
  output logic [NS_W-1:0]   rate_mag,
  output logic              step_add,
  output logic [WORD_W-1:0] step_sec,
  output logic [NS_W-1:0]   step_ns,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] set_sh, set_sm, set_sl, set_nl, rate_l, step_l;
  logic [HI_W-1:0]   set_nh, rate_h, step_h;
  logic              rate_dir, step_dir;
  logic              cmd_wr;
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    cmd_wr      = wr_en && (wr_addr == A_CMD);
    cmd.clr     = cmd_wr && wr_data[0];
    cmd.off     = cmd_wr && wr_data[1];
    cmd.on      = cmd_wr && wr_data[2];
    cmd.snap    = cmd_wr && wr_data[3];
    cmd.load    = cmd_wr && wr_data[4];
    cmd.step_s  = cmd_wr && wr_data[5];
    cmd.step_n  = cmd_wr && wr_data[6];
  end

  always_comb begin
    case (rd_addr)
      A_RATE_H: rd_mux = {rate_dir, 1'b0, rate_h};
      A_RATE_L: rd_mux = rate_l;
      A_RD_SH:  rd_mux = snap_sec[47:32];
      A_RD_SM:  rd_mux = snap_sec[31:16];
      A_RD_SL:  rd_mux = snap_sec[15:0];
      A_RD_NH:  rd_mux = {2'b00, snap_ns[NS_W-1:WORD_W]};
      A_RD_NL:  rd_mux = snap_ns[WORD_W-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_sh <= '0; set_sm <= '0; set_sl <= '0; set_nh <= '0; set_nl <= '0;
      rate_dir <= 1'b0; rate_h <= '0; rate_l <= '0;
      step_dir <= 1'b0; step_h <= '0; step_l <= '0;
      running <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_SET_SH: set_sh <= wr_data;
          A_SET_SM: set_sm <= wr_data;
          A_SET_SL: set_sl <= wr_data;
          A_SET_NH: set_nh <= wr_data[HI_W-1:0];
          A_SET_NL: set_nl <= wr_data;
          A_RATE_H: begin rate_dir <= wr_data[15]; rate_h <= wr_data[HI_W-1:0]; end
          A_RATE_L: rate_l <= wr_data;
          A_STEP_H: begin step_dir <= wr_data[15]; step_h <= wr_data[HI_W-1:0]; end
          A_STEP_L: step_l <= wr_data;
          default: ;
        endcase
      end
      if (cmd.clr) begin
        rate_dir <= 1'b0;
        rate_h   <= '0;
        rate_l   <= '0;
      end
      if (cmd.clr || cmd.off) running <= 1'b0;
      else if (cmd.on)        running <= 1'b1;
      rd_data <= rd_mux;
    end
  end

  assign set_sec   = {set_sh, set_sm, set_sl};
  assign set_ns    = {set_nh, set_nl};
  assign rate_fast = rate_dir;
  assign rate_mag  = {rate_h, rate_l};
  assign step_add  = step_dir;
  assign step_sec  = step_l;
  assign step_ns   = {step_h, step_l};

  // R9
  clr_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.clr |=> (rate_mag == '0) && !rate_fast && !running);

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wr_data[1]) |=> !running);
endmodule

// File: rtl/phc_rate.sv
module phc_rate
  import phc_pkg::*;
#(
  parameter int FRAC_W = 31,
  parameter int NOM_NS = 8,
  parameter int INC_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             fast,
  input  logic [NS_W-1:0]  mag,
  output logic [INC_W-1:0] inc
);
  localparam int PAD_W = FRAC_W + 1 - NS_W;

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum_up, sum_dn;
  logic              carry, borrow;

  always_comb begin
    sum_up = {1'b0, acc} + {{PAD_W{1'b0}}, mag};
    sum_dn = {1'b0, acc} - {{PAD_W{1'b0}}, mag};
    carry  = fast && sum_up[FRAC_W];
    borrow = !fast && sum_dn[FRAC_W];
    if (!tick)       inc = '0;
    else if (carry)  inc = INC_W'(NOM_NS + 1);
    else if (borrow) inc = INC_W'(NOM_NS - 1);
    else             inc = INC_W'(NOM_NS);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (tick)   acc <= fast ? sum_up[FRAC_W-1:0] : sum_dn[FRAC_W-1:0];
  end

  // R4
  fast_never_short_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && fast) |-> (inc >= INC_W'(NOM_NS)));

  // R4
  slow_never_long_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !fast) |-> (inc <= INC_W'(NOM_NS)));
endmodule

// File: rtl/phc_time.sv
module phc_time
  import phc_pkg::*;
#(
  parameter int INC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              cmd,
  input  logic [INC_W-1:0]  inc,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic [NS_W-1:0]   set_ns,
  input  logic              step_add,
  input  logic [WORD_W-1:0] step_sec,
  input  logic [NS_W-1:0]   step_ns,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NS_W-1:0]   ns_q,
  output logic [SEC_W-1:0]  snap_sec,
  output logic [NS_W-1:0]   snap_ns
);
  localparam logic [31:0] ONE_S = NS_PER_SEC;
  localparam logic [31:0] TWO_S = NS_PER_SEC + NS_PER_SEC;

  logic [31:0]      ns_sum, ld_sum;
  logic [NS_W-1:0]  ns_nx, ld_ns;
  logic [1:0]       carry;
  logic [SEC_W-1:0] sec_carried, sec_nx, ld_sec;

  always_comb begin
    ns_sum = 32'(ns_q) + 32'(inc) + (cmd.step_n ? 32'(step_ns) : 32'd0);
    if (ns_sum >= TWO_S) begin
      ns_nx = NS_W'(ns_sum - TWO_S); carry = 2'd2;
    end else if (ns_sum >= ONE_S) begin
      ns_nx = NS_W'(ns_sum - ONE_S); carry = 2'd1;
    end else begin
      ns_nx = NS_W'(ns_sum);         carry = 2'd0;
    end
    sec_carried = sec_q + SEC_W'(carry);
    if (cmd.step_s)
      sec_nx = step_add ? sec_carried + SEC_W'(step_sec) : sec_carried - SEC_W'(step_sec);
    else
      sec_nx = sec_carried;

    ld_sum = 32'(set_ns);
    if (ld_sum >= ONE_S) begin
      ld_ns  = NS_W'(ld_sum - ONE_S);
      ld_sec = set_sec + SEC_W'(1);
    end else begin
      ld_ns  = set_ns;
      ld_sec = set_sec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.clr) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (cmd.load) begin
      sec_q <= ld_sec;
      ns_q  <= ld_ns;
    end else begin
      sec_q <= sec_nx;
      ns_q  <= ns_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_sec <= '0;
      snap_ns  <= '0;
    end else if (cmd.snap) begin
      snap_sec <= sec_q;
      snap_ns  <= ns_q;
    end
  end

  // R3
  ns_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ns_q < NS_W'(NS_PER_SEC));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc == '0 && !cmd.clr && !cmd.load && !cmd.step_s && !cmd.step_n)
      |=> $stable(sec_q) && $stable(ns_q));

  // R5
  load_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.load && !cmd.clr && (32'(set_ns) < ONE_S))
      |=> (sec_q == $past(set_sec)) && (ns_q == $past(set_ns)));

  // R6
  snap_coherent_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.snap |=> (snap_sec == $past(sec_q)) && (snap_ns == $past(ns_q)));
endmodule

// File: rtl/ptp_hw_clock.sv
module ptp_hw_clock
  import phc_pkg::*;
#(
  parameter int FRAC_W = 31,
  parameter int NOM_NS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic [3:0]  rd_addr_i,
  output logic [15:0] rd_data_o,
  output logic [47:0] time_sec_o,
  output logic [29:0] time_ns_o
);
  localparam int INC_W = $clog2(NOM_NS + 2);

  cmd_t              cmd;
  logic              running, rate_fast, step_add;
  logic [SEC_W-1:0]  set_sec, snap_sec;
  logic [NS_W-1:0]   set_ns, rate_mag, step_ns, snap_ns;
  logic [WORD_W-1:0] step_sec;
  logic [INC_W-1:0]  inc;

  phc_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .snap_sec(snap_sec), .snap_ns(snap_ns),
    .cmd(cmd), .running(running),
    .set_sec(set_sec), .set_ns(set_ns),
    .rate_fast(rate_fast), .rate_mag(rate_mag),
    .step_add(step_add), .step_sec(step_sec), .step_ns(step_ns),
    .rd_data(rd_data_o)
  );

  phc_rate #(.FRAC_W(FRAC_W), .NOM_NS(NOM_NS), .INC_W(INC_W)) u_rate (
    .clk(clk), .rst(rst), .clr(cmd.clr),
    .tick(tick_i && running),
    .fast(rate_fast), .mag(rate_mag), .inc(inc)
  );

  phc_time #(.INC_W(INC_W)) u_time (
    .clk(clk), .rst(rst), .cmd(cmd), .inc(inc),
    .set_sec(set_sec), .set_ns(set_ns),
    .step_add(step_add), .step_sec(step_sec), .step_ns(step_ns),
    .sec_q(time_sec_o), .ns_q(time_ns_o),
    .snap_sec(snap_sec), .snap_ns(snap_ns)
  );
endmodule

// File: tb/ptp_hw_clock_tb_top.sv
module ptp_hw_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [47:0] t_sec;
  logic [29:0] t_ns;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam longint BILLION = 64'd1000000000;
  localparam longint TWO31   = 64'd1 << 31;
  localparam longint MASK48  = (64'd1 << 48) - 1;

  ptp_hw_clock dut_i (
    .clk(clk), .rst(rst), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .time_sec_o(t_sec), .time_ns_o(t_ns)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  longint m_sec = 0, m_ns = 0, m_acc = 0, m_ssec = 0, m_sns = 0;
  bit m_en = 1'b0;
  logic [15:0] m_w [16];
  logic [15:0] m_rd = '0;

  initial for (int i = 0; i < 16; i++) m_w[i] = '0;

  always @(posedge clk) begin
    longint s, n, a, mag;
    int inc;
    logic [15:0] c;
    if (rst) begin
      m_sec = 0; m_ns = 0; m_acc = 0; m_ssec = 0; m_sns = 0; m_en = 0; m_rd = '0;
      for (int i = 0; i < 16; i++) m_w[i] = '0;
    end else begin
      case (rd_addr)
        4'd6:  m_rd = m_w[6];
        4'd7:  m_rd = m_w[7];
        4'd10: m_rd = 16'((m_ssec >> 32) & 64'hFFFF);
        4'd11: m_rd = 16'((m_ssec >> 16) & 64'hFFFF);
        4'd12: m_rd = 16'(m_ssec & 64'hFFFF);
        4'd13: m_rd = 16'(m_sns >> 16);
        4'd14: m_rd = 16'(m_sns & 64'hFFFF);
        default: m_rd = '0;
      endcase
      c = (wr_en && wr_addr == 4'd0) ? wr_data : 16'd0;
      mag = longint'({m_w[6][13:0], m_w[7]});
      a = m_acc;
      inc = 0;
      if (tick && m_en) begin
        inc = 8;
        if (m_w[6][15]) begin
          a = a + mag;
          if (a >= TWO31) begin a = a - TWO31; inc = 9; end
        end else begin
          a = a - mag;
          if (a < 0) begin a = a + TWO31; inc = 7; end
        end
      end
      if (c[3]) begin m_ssec = m_sec; m_sns = m_ns; end
      if (c[0]) begin
        s = 0; n = 0; a = 0; m_w[6] = '0; m_w[7] = '0;
      end else if (c[4]) begin
        s = longint'({m_w[1], m_w[2], m_w[3]});
        n = longint'({m_w[4][13:0], m_w[5]});
        if (n >= BILLION) begin n = n - BILLION; s = s + 1; end
      end else begin
        n = m_ns + inc;
        if (c[6]) n = n + longint'({m_w[8][13:0], m_w[9]});
        s = m_sec;
        while (n >= BILLION) begin n = n - BILLION; s = s + 1; end
        if (c[5]) s = m_w[8][15] ? s + longint'(m_w[9]) : s - longint'(m_w[9]);
      end
      m_sec = s & MASK48;
      m_ns = n;
      m_acc = a;
      if (c[0] || c[1]) m_en = 0;
      else if (c[2]) m_en = 1;
      if (wr_en && wr_addr != 4'd0) begin
        if (wr_addr == 4'd6) m_w[6] = {wr_data[15], 1'b0, wr_data[13:0]};
        else m_w[wr_addr] = wr_data;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R3 live time, R10 read data)
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      chk("R3 model seconds", longint'(t_sec), m_sec);
      chk("R3 model nanoseconds", longint'(t_ns), m_ns);
      chk("R10 model read data", longint'(rd_data), longint'(m_rd));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_time(input longint s, input longint n);
    wr(4'd1, 16'((s >> 32) & 64'hFFFF));
    wr(4'd2, 16'((s >> 16) & 64'hFFFF));
    wr(4'd3, 16'(s & 64'hFFFF));
    wr(4'd4, 16'(n >> 16));
    wr(4'd5, 16'(n & 64'hFFFF));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 seconds after reset", longint'(t_sec), 0);
    chk("R1 ns after reset", longint'(t_ns), 0);
    rd(4'd6, d); chk("R1 rate word after reset", longint'(d), 0);
    // R2 stopped counter ignores ticks
    ticks(3);
    chk("R2 stopped ignores ticks", longint'(t_ns), 0);
    // R3 nominal advance
    wr(4'd0, 16'h0004);
    ticks(10);
    chk("R3 ten ticks", longint'(t_ns), 80);
    // R2 stop beats start
    wr(4'd0, 16'h0006);
    ticks(5);
    chk("R2 stop wins over start", longint'(t_ns), 80);
    wr(4'd0, 16'h0004);
    // R5 load
    set_time(64'h0001_0002_0003, 999999992);
    wr(4'd0, 16'h0010);
    chk("R5 load seconds", longint'(t_sec), 64'h0001_0002_0003);
    chk("R5 load ns", longint'(t_ns), 999999992);
    ticks(1);
    chk("R3 wrap ns", longint'(t_ns), 0);
    chk("R3 wrap carries second", longint'(t_sec), 64'h0001_0002_0004);
    // R5 staged ns at/above one second
    set_time(64'h0001_0002_0003, 1000000005);
    wr(4'd0, 16'h0010);
    chk("R5 oversize ns wraps", longint'(t_ns), 5);
    chk("R5 oversize ns carries", longint'(t_sec), 64'h0001_0002_0004);
    // R6 snapshot
    wr(4'd0, 16'h0008);
    ticks(2);
    chk("R3 live after snapshot", longint'(t_ns), 21);
    rd(4'd10, d); chk("R6 snap sec high", longint'(d), 1);
    rd(4'd11, d); chk("R6 snap sec mid", longint'(d), 2);
    rd(4'd12, d); chk("R6 snap sec low", longint'(d), 4);
    rd(4'd13, d); chk("R6 snap ns high", longint'(d), 0);
    rd(4'd14, d); chk("R6 snap ns low held", longint'(d), 5);
    // R7 seconds steps
    wr(4'd8, 16'h8000); wr(4'd9, 16'd15); wr(4'd0, 16'h0020);
    chk("R7 step add", longint'(t_sec), 64'h0001_0002_0013);
    wr(4'd8, 16'h0000); wr(4'd9, 16'd3); wr(4'd0, 16'h0020);
    chk("R7 step subtract", longint'(t_sec), 64'h0001_0002_0010);
    chk("R7 ns untouched", longint'(t_ns), 21);
    // R8 ns step with tick in same cycle, double carry
    set_time(0, 999999000);
    wr(4'd0, 16'h0010);
    wr(4'd8, 16'h3FFF); wr(4'd9, 16'hFFFF);
    tick = 1'b1;
    wr(4'd0, 16'h0040);
    tick = 1'b0;
    chk("R8 ns step double wrap", longint'(t_ns), 73740831);
    chk("R8 ns step carries two", longint'(t_sec), 2);
    // R7 wrap below zero
    set_time(0, 0);
    wr(4'd0, 16'h0010);
    wr(4'd8, 16'h0000); wr(4'd9, 16'd1); wr(4'd0, 16'h0020);
    chk("R7 seconds wrap below zero", longint'(t_sec), MASK48);
    // R9 clear
    wr(4'd6, 16'hA000);
    wr(4'd0, 16'h0001);
    chk("R9 clear seconds", longint'(t_sec), 0);
    rd(4'd6, d); chk("R9 clear rate", longint'(d), 0);
    ticks(2);
    chk("R9 clear stops counter", longint'(t_ns), 0);
    // R4 faster: 2^29 magnitude
    wr(4'd6, 16'hE000);
    rd(4'd6, d); chk("R10 rate readback masks bit 14", longint'(d), 16'hA000);
    wr(4'd0, 16'h0004);
    ticks(8);
    chk("R4 faster eight ticks", longint'(t_ns), 66);
    // R4 slower
    wr(4'd0, 16'h0001);
    wr(4'd6, 16'h2000);
    wr(4'd0, 16'h0004);
    ticks(8);
    chk("R4 slower eight ticks", longint'(t_ns), 62);
    // R11 priority and single action
    wr(4'd6, 16'h0000);
    set_time(7, 0);
    wr(4'd0, 16'h0011);
    chk("R11 clear beats load", longint'(t_sec), 0);
    wr(4'd0, 16'h0030);
    chk("R11 load beats step", longint'(t_sec), 7);
    repeat (3) @(negedge clk);
    chk("R11 command acts once", longint'(t_sec), 7);
    // R10 unmapped and write-only reads
    rd(4'd15, d); chk("R10 unmapped reads zero", longint'(d), 0);
    rd(4'd1, d);  chk("R10 set word reads zero", longint'(d), 0);
    // random traffic against the model
    wr(4'd0, 16'h0004);
    for (int k = 0; k < 3000; k++) begin
      tick = ($urandom % 4) != 0;
      rd_addr = 4'($urandom % 16);
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1;
        wr_addr = 4'($urandom % 10);
        wr_data = 16'($urandom);
        if (wr_addr == 4'd0) wr_data = (($urandom % 16) == 0) ? (wr_data & 16'h007F) : (wr_data & 16'h007E) | 16'h0004;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule